// File: doc/BRIEF.md
# Banked Interrupt Gate with IRQ/FIQ Steering

This block collects a group of level-sensitive interrupt lines, up to 32 per bank, and presents them to two processors: a main CPU and a coprocessor. Each processor has its own enable mask and its own class mask. A source that is pending and enabled for a processor drives that processor's normal interrupt (IRQ) output when its class bit is clear, and its fast interrupt (FIQ) output when its class bit is set. Software can force any source pending through a force register. This re-triggers an interrupt, and clearing the force bit acknowledges the interrupt at the end of service.

Software reaches the bank over a plain 32-bit register bus with byte offsets, one word per register. The enable and force masks are never written directly. Each has an alias that sets the bits written as one and an alias that clears the bits written as one, so a single write can change single bits without a read-modify-write sequence. To leave only wake-up sources active before a low-power entry, software writes all ones to the clear alias and then writes the wake mask to the set alias. A system builds the full interrupt space by placing several banks side by side, with source n on bank n/32 at bit n%32; the decoding between banks sits outside this block.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset, the force mask, both enable masks and both class masks are all zero, and all four interrupt outputs stay low whatever the source inputs are.
- R2: A write to offset 0x24 ORs the write data into the CPU enable mask, and a write to 0x28 clears the bits of that mask where the data is one. All other bits keep their value. The new value is visible on the outputs and on reads from the first clock edge after the write.
- R3: The coprocessor enable mask works the same way, with its set alias at 0x34 and its clear alias at 0x38.
- R4: The CPU class mask at 0x2C and the coprocessor class mask at 0x3C are plain read/write registers. A class bit of 0 steers that source to the IRQ output and a bit of 1 steers it to the FIQ output.
- R5: A write to 0x18 sets bits in the force mask and a write to 0x1C clears them. A source counts as pending when its input line is high or its force bit is set.
- R6: For each processor, the IRQ output is high exactly when some source is pending, enabled for that processor and has its class bit at 0. The FIQ output is high exactly when some such source has its class bit at 1.
- R7: A read returns, with no clock delay: the force mask at 0x14, 0x18 and 0x1C; the CPU enable mask at 0x20, 0x24 and 0x28; the coprocessor enable mask at 0x30, 0x34 and 0x38; each class mask at its own offset; and, at 0x08, the sources that are pending, CPU-enabled and CPU-class FIQ. Every other offset, and all bits above the source count, read as zero.
- R8: Writes to 0x08, 0x14, 0x20, 0x30 and to unmapped offsets change no register.
- R9: A write of all ones to 0x28 followed by a mask written to 0x24 leaves exactly the bits of that mask enabled for the CPU.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC (32) | Level interrupt inputs, one per source |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | AW (8) | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cpu_irq_o | output | 1 | CPU normal interrupt request |
| cpu_fiq_o | output | 1 | CPU fast interrupt request |
| cop_irq_o | output | 1 | Coprocessor normal interrupt request |
| cop_fiq_o | output | 1 | Coprocessor fast interrupt request |

## Verification
A register write and a change on an interrupt input can land in the same cycle. The critical case is a clear of a force bit while the hardware line for that source is still high, which must keep the request asserted. The bench provokes this on purpose and also sets up the opposite case, where a force bit is cleared in the same cycle its input line falls. A long random phase then mixes bus writes to every offset with random source patterns in the same cycles. Every cycle, a per-bit behavioural model is compared against all four outputs and the read data, so a request that is dropped or left standing one cycle too long is caught in the cycle where it happens.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

   // Register offsets (byte addresses on the bus)
   localparam int unsigned OFS_FIQ_VIEW = 'h08;
   localparam int unsigned OFS_FORCE    = 'h14;
   localparam int unsigned OFS_CPU_EN   = 'h20;
   localparam int unsigned OFS_CPU_CLS  = 'h2C;
   localparam int unsigned OFS_COP_EN   = 'h30;
   localparam int unsigned OFS_COP_CLS  = 'h3C;

   // Alias distance from a set/clear register's readable location
   localparam int unsigned STEP_SET = 4;
   localparam int unsigned STEP_CLR = 8;

   // Field and processor counts
   localparam int unsigned NFLD  = 5;
   localparam int unsigned NPROC = 2;

   typedef enum logic [0:0] {
      KIND_SETCLR = 1'b0,
      KIND_PLAIN  = 1'b1
   } irqb_kind_e;

   typedef struct packed {
      logic irq;
      logic fiq;
   } irqb_line_t;

   // Field index map: 0 force, 1 cpu enable, 2 cpu class, 3 cop enable, 4 cop class
   function automatic int unsigned fld_base(input int unsigned idx);
      case (idx)
         0:       return OFS_FORCE;
         1:       return OFS_CPU_EN;
         2:       return OFS_CPU_CLS;
         3:       return OFS_COP_EN;
         default: return OFS_COP_CLS;
      endcase
   endfunction

   function automatic irqb_kind_e fld_kind(input int unsigned idx);
      return (idx == 2 || idx == 4) ? KIND_PLAIN : KIND_SETCLR;
   endfunction

   function automatic int unsigned en_idx(input int unsigned proc);
      return 1 + 2 * proc;
   endfunction

   function automatic int unsigned cls_idx(input int unsigned proc);
      return 2 + 2 * proc;
   endfunction

endpackage

// File: rtl/irqb_field.sv
module irqb_field #(
   parameter int unsigned          W    = 32,
   parameter int unsigned          AW   = 8,
   parameter int unsigned          BASE = 0,
   parameter irqb_pkg::irqb_kind_e KIND = irqb_pkg::KIND_SETCLR
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  q
);

   logic [W-1:0] nxt_q;

   generate
      if (KIND == irqb_pkg::KIND_SETCLR) begin : g_setclr
         localparam logic [AW-1:0] SET_A = AW'(BASE + irqb_pkg::STEP_SET);
         localparam logic [AW-1:0] CLR_A = AW'(BASE + irqb_pkg::STEP_CLR);
         always_comb begin
            nxt_q = q;
            if (we && addr == SET_A) begin
               nxt_q = q | wdata;
            end else if (we && addr == CLR_A) begin
               nxt_q = q & ~wdata;
            end
         end
      end else begin : g_plain
         localparam logic [AW-1:0] RW_A = AW'(BASE);
         always_comb begin
            nxt_q = q;
            if (we && addr == RW_A) begin
               nxt_q = wdata;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         q <= nxt_q;
      end
   end

endmodule

// File: rtl/irqb_route.sv
module irqb_route #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0]          pend,
   input  logic [W-1:0]          en,
   input  logic [W-1:0]          cls,
   output irqb_pkg::irqb_line_t  line
);

   logic [W-1:0] active;

   assign active   = pend & en;
   assign line.irq = |(active & ~cls);
   assign line.fiq = |(active & cls);

endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl #(
   parameter int unsigned NSRC = 32,
   parameter int unsigned AW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_i,
   input  logic            bus_we,
   input  logic [AW-1:0]   bus_addr,
   input  logic [31:0]     bus_wdata,
   output logic [31:0]     bus_rdata,
   output logic            cpu_irq_o,
   output logic            cpu_fiq_o,
   output logic            cop_irq_o,
   output logic            cop_fiq_o
);
   import irqb_pkg::*;

   generate
      if (NSRC < 1 || NSRC > 32) begin : g_bad_nsrc
         $error("irq_bank_ctrl: NSRC must lie in 1..32");
      end
      if (AW < 6) begin : g_bad_aw
         $error("irq_bank_ctrl: AW must reach offset 0x3C");
      end
   endgenerate

   localparam logic [AW-1:0] A_FIQ  = AW'(OFS_FIQ_VIEW);
   localparam logic [AW-1:0] A_FRC  = AW'(OFS_FORCE);
   localparam logic [AW-1:0] A_FRCS = AW'(OFS_FORCE + STEP_SET);
   localparam logic [AW-1:0] A_FRCC = AW'(OFS_FORCE + STEP_CLR);
   localparam logic [AW-1:0] A_CEN  = AW'(OFS_CPU_EN);
   localparam logic [AW-1:0] A_CENS = AW'(OFS_CPU_EN + STEP_SET);
   localparam logic [AW-1:0] A_CENC = AW'(OFS_CPU_EN + STEP_CLR);
   localparam logic [AW-1:0] A_CCLS = AW'(OFS_CPU_CLS);
   localparam logic [AW-1:0] A_OEN  = AW'(OFS_COP_EN);
   localparam logic [AW-1:0] A_OENS = AW'(OFS_COP_EN + STEP_SET);
   localparam logic [AW-1:0] A_OENC = AW'(OFS_COP_EN + STEP_CLR);
   localparam logic [AW-1:0] A_OCLS = AW'(OFS_COP_CLS);

   logic [NFLD-1:0][NSRC-1:0] fld_q;
   logic [NSRC-1:0]           wd;
   logic [NSRC-1:0]           frc;
   logic [NSRC-1:0]           cpu_en;
   logic [NSRC-1:0]           cpu_cls;
   logic [NSRC-1:0]           cop_en;
   logic [NSRC-1:0]           cop_cls;
   logic [NSRC-1:0]           pend;
   logic [NSRC-1:0]           fiq_view;
   logic [NSRC-1:0]           rd_w;
   irqb_line_t [NPROC-1:0]    line;

   assign wd = bus_wdata[NSRC-1:0];

   // Register fields
   generate
      for (genvar g = 0; g < NFLD; g++) begin : g_fld
         irqb_field #(
            .W    (NSRC),
            .AW   (AW),
            .BASE (fld_base(g)),
            .KIND (fld_kind(g))
         ) u_fld (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bus_we),
            .addr  (bus_addr),
            .wdata (wd),
            .q     (fld_q[g])
         );
      end
   endgenerate

   assign frc     = fld_q[0];
   assign cpu_en  = fld_q[en_idx(0)];
   assign cpu_cls = fld_q[cls_idx(0)];
   assign cop_en  = fld_q[en_idx(1)];
   assign cop_cls = fld_q[cls_idx(1)];

   assign pend     = src_i | frc;
   assign fiq_view = pend & cpu_en & cpu_cls;

   // Per-processor steering
   generate
      for (genvar p = 0; p < NPROC; p++) begin : g_proc
         irqb_route #(
            .W (NSRC)
         ) u_route (
            .pend (pend),
            .en   (fld_q[en_idx(p)]),
            .cls  (fld_q[cls_idx(p)]),
            .line (line[p])
         );
      end
   endgenerate

   assign cpu_irq_o = line[0].irq;
   assign cpu_fiq_o = line[0].fiq;
   assign cop_irq_o = line[1].irq;
   assign cop_fiq_o = line[1].fiq;

   // Read path
   always_comb begin
      case (bus_addr)
         A_FIQ:                 rd_w = fiq_view;
         A_FRC, A_FRCS, A_FRCC: rd_w = frc;
         A_CEN, A_CENS, A_CENC: rd_w = cpu_en;
         A_CCLS:                rd_w = cpu_cls;
         A_OEN, A_OENS, A_OENC: rd_w = cop_en;
         A_OCLS:                rd_w = cop_cls;
         default:               rd_w = '0;
      endcase
   end

   assign bus_rdata = 32'(rd_w);

endmodule

// File: rtl/irqb_chk.sv
module irqb_chk #(
   parameter int unsigned NSRC = 32,
   parameter int unsigned AW   = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_we,
   input logic [AW-1:0]   bus_addr,
   input logic [31:0]     bus_wdata,
   input logic [NSRC-1:0] frc,
   input logic [NSRC-1:0] cpu_en,
   input logic [NSRC-1:0] cpu_cls,
   input logic [NSRC-1:0] cop_en,
   input logic [NSRC-1:0] cop_cls,
   input logic            cpu_irq_o,
   input logic            cpu_fiq_o,
   input logic            cop_irq_o,
   input logic            cop_fiq_o
);
   import irqb_pkg::*;

   localparam logic [AW-1:0] C_FIQ  = AW'(OFS_FIQ_VIEW);
   localparam logic [AW-1:0] C_FRC  = AW'(OFS_FORCE);
   localparam logic [AW-1:0] C_FRCC = AW'(OFS_FORCE + STEP_CLR);
   localparam logic [AW-1:0] C_CEN  = AW'(OFS_CPU_EN);
   localparam logic [AW-1:0] C_CENS = AW'(OFS_CPU_EN + STEP_SET);
   localparam logic [AW-1:0] C_CENC = AW'(OFS_CPU_EN + STEP_CLR);
   localparam logic [AW-1:0] C_OEN  = AW'(OFS_COP_EN);
   localparam logic [AW-1:0] C_OENS = AW'(OFS_COP_EN + STEP_SET);
   localparam logic [AW-1:0] C_OENC = AW'(OFS_COP_EN + STEP_CLR);

   logic [NSRC-1:0] wd;
   assign wd = bus_wdata[NSRC-1:0];

   // R2
   cpu_en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == C_CENS) |=> ((cpu_en & $past(wd)) == $past(wd)));

   // R2
   cpu_en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == C_CENC) |=> ((cpu_en & $past(wd)) == '0));

   // R3
   cop_en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == C_OENS) |=> ((cop_en & $past(wd)) == $past(wd)));

   // R3
   cop_en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == C_OENC) |=> ((cop_en & $past(wd)) == '0));

   // R5
   force_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == C_FRCC) |=> ((frc & $past(wd)) == '0));

   // R8
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (bus_addr == C_FIQ || bus_addr == C_FRC ||
                  bus_addr == C_CEN || bus_addr == C_OEN))
      |=> ($stable(frc) && $stable(cpu_en) && $stable(cop_en)));

   // R6
   cpu_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq_o |-> ((cpu_en & ~cpu_cls) != '0));

   // R6
   cpu_fiq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_fiq_o |-> ((cpu_en & cpu_cls) != '0));

   // R6
   cop_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cop_irq_o |-> ((cop_en & ~cop_cls) != '0));

   // R6
   cop_fiq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cop_fiq_o |-> ((cop_en & cop_cls) != '0));

endmodule

bind irq_bank_ctrl irqb_chk #(
   .NSRC (NSRC),
   .AW   (AW)
) u_irqb_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .frc       (frc),
   .cpu_en    (cpu_en),
   .cpu_cls   (cpu_cls),
   .cop_en    (cop_en),
   .cop_cls   (cop_cls),
   .cpu_irq_o (cpu_irq_o),
   .cpu_fiq_o (cpu_fiq_o),
   .cop_irq_o (cop_irq_o),
   .cop_fiq_o (cop_fiq_o)
);

// File: tb/test_irq_bank_ctrl.sv
module test_irq_bank_ctrl;

   logic        clk   = 1'b0;
   logic        rst_n = 1'b0;
   logic        we    = 1'b0;
   logic [7:0]  addr  = '0;
   logic [31:0] wdata = '0;
   logic [31:0] src   = '0;
   logic [31:0] rdata;
   logic        cpu_irq, cpu_fiq, cop_irq, cop_fiq;

   // Reference model state
   logic [31:0] m_frc = '0, m_cen = '0, m_ccl = '0, m_oen = '0, m_ocl = '0;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   irq_bank_ctrl i_irq_bank_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src),
      .bus_we    (we),
      .bus_addr  (addr),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .cpu_irq_o (cpu_irq),
      .cpu_fiq_o (cpu_fiq),
      .cop_irq_o (cop_irq),
      .cop_fiq_o (cop_fiq)
   );

   // Behavioural register model, updated on each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_frc <= '0; m_cen <= '0; m_ccl <= '0; m_oen <= '0; m_ocl <= '0;
      end else if (we) begin
         if (addr == 8'h18) m_frc <= m_frc | wdata;
         if (addr == 8'h1C) m_frc <= m_frc & ~wdata;
         if (addr == 8'h24) m_cen <= m_cen | wdata;
         if (addr == 8'h28) m_cen <= m_cen & ~wdata;
         if (addr == 8'h2C) m_ccl <= wdata;
         if (addr == 8'h34) m_oen <= m_oen | wdata;
         if (addr == 8'h38) m_oen <= m_oen & ~wdata;
         if (addr == 8'h3C) m_ocl <= wdata;
      end
   end

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      logic [31:0] v = '0;
      for (int i = 0; i < 32; i++) begin
         if ((src[i] || m_frc[i]) && m_cen[i] && m_ccl[i]) v[i] = 1'b1;
      end
      if (a == 8'h08) return v;
      if (a == 8'h14 || a == 8'h18 || a == 8'h1C) return m_frc;
      if (a == 8'h20 || a == 8'h24 || a == 8'h28) return m_cen;
      if (a == 8'h2C) return m_ccl;
      if (a == 8'h30 || a == 8'h34 || a == 8'h38) return m_oen;
      if (a == 8'h3C) return m_ocl;
      return 32'h0;
   endfunction

   function automatic logic [3:0] exp_lines();
      logic ci = 0, cf = 0, oi = 0, of_ = 0;
      for (int i = 0; i < 32; i++) begin
         if (src[i] || m_frc[i]) begin
            if (m_cen[i]) begin
               if (m_ccl[i]) cf = 1; else ci = 1;
            end
            if (m_oen[i]) begin
               if (m_ocl[i]) of_ = 1; else oi = 1;
            end
         end
      end
      return {ci, cf, oi, of_};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // One bus cycle: drive at the falling edge, compare before the rising edge
   task automatic cyc(input string req, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input logic [31:0] s);
      we = w; addr = a; wdata = d; src = s;
      #2;
      check("R6", "lines", {28'h0, cpu_irq, cpu_fiq, cop_irq, cop_fiq},
            {28'h0, exp_lines()});
      check(req, "rdata", rdata, exp_read(a));
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hang, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] offs [16] = '{8'h00, 8'h08, 8'h14, 8'h18, 8'h1C, 8'h20,
                               8'h24, 8'h28, 8'h2C, 8'h30, 8'h34, 8'h38,
                               8'h3C, 8'h40, 8'h10, 8'h04};
      @(negedge clk);
      @(negedge clk);
      // R1: reset state, sources high yet no request
      cyc("R1", 0, 8'h20, 0, '1);
      rst_n = 1'b1;
      cyc("R1", 0, 8'h14, 0, '1);
      cyc("R1", 0, 8'h2C, 0, '1);
      cyc("R1", 0, 8'h30, 0, '1);
      cyc("R1", 0, 8'h3C, 0, '1);
      cyc("R1", 0, 8'h08, 0, '1);

      // R2: cpu enable set/clear aliases
      cyc("R2", 1, 8'h24, 32'h0000_00F0, 0);
      cyc("R2", 0, 8'h20, 0, 32'h0000_0010);
      cyc("R2", 1, 8'h24, 32'h8000_0001, 0);
      cyc("R2", 1, 8'h28, 32'h0000_0030, 32'h8000_0000);
      cyc("R7", 0, 8'h24, 0, 0);
      cyc("R7", 0, 8'h28, 0, 32'h0000_0040);

      // R3: coprocessor enable aliases
      cyc("R3", 1, 8'h34, 32'h0F0F_0000, 0);
      cyc("R3", 1, 8'h38, 32'h0300_0000, 32'h0100_0000);
      cyc("R3", 0, 8'h30, 0, 32'h0400_0000);
      cyc("R7", 0, 8'h38, 0, 0);

      // R4: class steering to FIQ
      cyc("R4", 1, 8'h2C, 32'h0000_0080, 0);
      cyc("R4", 0, 8'h2C, 0, 32'h0000_0080);
      cyc("R7", 0, 8'h08, 0, 32'h0000_00C0);
      cyc("R4", 1, 8'h3C, 32'h0400_0000, 0);
      cyc("R4", 0, 8'h3C, 0, 32'h0400_0000);

      // R5: forced interrupts, set then acknowledge
      cyc("R5", 1, 8'h18, 32'h0000_0041, 0);
      cyc("R5", 0, 8'h14, 0, 0);
      cyc("R5", 1, 8'h1C, 32'h0000_0001, 0);
      cyc("R5", 0, 8'h18, 0, 0);

      // Same-cycle: force cleared while the line stays high, then while it falls
      cyc("R5", 1, 8'h1C, 32'h0000_0040, 32'h0000_0040);
      cyc("R5", 0, 8'h1C, 0, 32'h0000_0040);
      cyc("R5", 1, 8'h18, 32'h0000_0020, 32'h0000_0020);
      cyc("R5", 1, 8'h1C, 32'h0000_0020, 0);
      cyc("R5", 0, 8'h14, 0, 0);

      // R8: writes to read-only and unmapped offsets
      cyc("R8", 1, 8'h08, '1, 0);
      cyc("R8", 1, 8'h14, '1, 0);
      cyc("R8", 1, 8'h20, 32'h0, 0);
      cyc("R8", 1, 8'h30, 32'h0, 0);
      cyc("R8", 1, 8'h00, '1, 0);
      cyc("R8", 1, 8'h40, '1, 0);
      cyc("R8", 0, 8'h20, 0, 0);
      cyc("R8", 0, 8'h30, 0, 0);
      cyc("R8", 0, 8'h14, 0, 0);

      // R9: wipe all then enable only the wake mask
      cyc("R9", 1, 8'h28, '1, 0);
      cyc("R9", 0, 8'h20, 0, 0);
      cyc("R9", 1, 8'h24, 32'h0000_1004, 0);
      cyc("R9", 0, 8'h20, 0, 32'h0000_1000);

      // R7: random mix of writes and source patterns
      for (int k = 0; k < 600; k++) begin
         logic [31:0] d = $urandom;
         logic [31:0] s = $urandom & $urandom;
         cyc("R7", 1'($urandom_range(0, 1)), offs[$urandom_range(0, 15)], d, s);
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule